// File: doc/BRIEF.md
# Vector load address sequencer

This block turns one vectorised load into a series of per-element memory requests. The caller supplies the instruction's operand description: a scalar-or-vector flag for the destination and for each address operand, a choice between immediate and indexed addressing, an element-stride select, a 2-bit element-size code, the vector length, the immediate and the scalar values of the two address operands. Which operands are vectors picks the access pattern. The patterns are contiguous, constant stride, gather, select into a fixed destination, and splat of one location into several registers.

Start is sampled on a rising clock edge while the block is idle. The block copies the operation into internal registers and drives requests on a valid/ready stream. Each request carries a byte address, a destination register number and a destination write-enable. Back-pressure rules: a request stays valid, with unchanged address and destination, for as long as `req_ready` is low. A request is taken on any rising edge where `req_valid` and `req_ready` are both high. Elements leave in ascending index order. In gather modes the per-element register holding the address is read through a combinational register-file read port (`rf_raddr` out, `rf_rdata` in).

A one-cycle `done` pulse marks the end of an operation. A one-cycle `err` pulse marks a combination the block rejects.

Top module: `vld_addr_seq`

## Requirements
- R1: Immediate mode, vector destination, scalar RA, element stride off: element i goes to address RA + imm + (i << size) and to register RT+i. Here size is the elem_size code: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8.
- R2: Immediate mode, vector destination, scalar RA, element stride on: element i goes to address RA + imm*i and to register RT+i.
- R3: Immediate mode with vector RA and vector destination: element i reads register number RA+i through the read port, goes to address imm + that value, and goes to register RT+i.
- R4: Immediate mode with vector RA and scalar destination: VL requests are issued with addresses as in R3, and every request names register RT.
- R5: When the destination and all used address operands are scalar, exactly one request is issued whatever VL is. Its address is RA + imm in immediate mode and RA + RB in indexed mode, and its destination is RT.
- R6: Indexed mode, vector destination, vector RB (RA either kind): element i goes to address RA + RB + (i << size) and to register RT+i.
- R7: Indexed mode, vector destination, vector RA, scalar RB: element i goes to address reg[RA+i] + RB and to register RT+i.
- R8: Indexed mode, vector destination, both address operands scalar: every element uses address RA + RB, and element i goes to register RT+i.
- R9: Elements leave in ascending index. While a request is valid and not ready, it stays valid with the same address and destination. req_wen is high with every request.
- R10: done pulses for one cycle, in the cycle after the last handshake. With VL = 0 (in any mode other than R5), no request is issued and done pulses in the cycle after start.
- R11: Indexed mode with a scalar destination and either address operand vector: err pulses in the cycle after start, and neither a request nor done follows.
- R12: start is ignored while an operation is in progress. The new operand values do not change the running sequence.
- R13: During and after reset, req_valid, done, err and busy are low. Register numbers wrap modulo 2^RW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dst_vec | input | 1 | Destination is a vector |
| ra_vec | input | 1 | RA operand is a vector |
| rb_vec | input | 1 | RB operand is a vector (indexed mode only) |
| idx_mode | input | 1 | 1 = indexed (RA+RB), 0 = immediate (imm+RA) |
| elem_stride | input | 1 | Element-stride select for immediate mode |
| elem_size | input | 2 | log2 of element size in bytes |
| vl | input | VLW | Vector length |
| imm | input | AW | Immediate offset |
| ra_val | input | AW | Scalar value of RA |
| rb_val | input | AW | Scalar value of RB |
| rt_num | input | RW | First destination register number |
| ra_num | input | RW | First RA register number for gathers |
| rf_raddr | output | RW | Register-file read address |
| rf_rdata | input | AW | Register-file read data (combinational) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Downstream ready |
| req_addr | output | AW | Element byte address |
| req_dst | output | RW | Element destination register |
| req_wen | output | 1 | Destination write-enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-mode pulse |

## Verification
Element 0 becomes valid in the cycle after the edge that takes start. Each later element appears in the cycle after the handshake edge of the one before. done shows in the cycle after the last handshake, and err in the cycle after start. The bench drives inputs and ready on the falling edge and samples one nanosecond later. It counts cycles from the first sample after start, so it can check that done arrives exactly one cycle after the last accepted element, and that done or err arrives at cycle 0 for the empty and rejected cases. A request that is stalled is compared in the next sample against the copy the bench saved.

// File: rtl/vld_pkg.sv
package vld_pkg;
  typedef enum logic [2:0] {
    M_SCALAR   = 3'd0,
    M_UNIT     = 3'd1,
    M_ELSTRIDE = 3'd2,
    M_GATHER   = 3'd3,
    M_SPLAT    = 3'd4,
    M_BAD      = 3'd5
  } amode_e;
endpackage

// File: rtl/vld_mode_decode.sv
module vld_mode_decode
  import vld_pkg::*;
(
  input  logic   dst_vec,
  input  logic   ra_vec,
  input  logic   rb_vec,
  input  logic   idx_mode,
  input  logic   elem_stride,
  output amode_e mode,
  output logic   dst_adv
);
  always_comb begin
    dst_adv = dst_vec;
    if (!idx_mode) begin
      if (ra_vec)       mode = M_GATHER;
      else if (dst_vec) mode = elem_stride ? M_ELSTRIDE : M_UNIT;
      else              mode = M_SCALAR;
    end else begin
      if (!dst_vec)     mode = (ra_vec || rb_vec) ? M_BAD : M_SCALAR;
      else if (rb_vec)  mode = M_UNIT;
      else if (ra_vec)  mode = M_GATHER;
      else              mode = M_SPLAT;
    end
  end
endmodule

// File: rtl/vld_elem_ctr.sv
module vld_elem_ctr #(
  parameter int CW = 7,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] step,
  input  logic          ready,
  output logic          busy,
  output logic [CW-1:0] idx,
  output logic [AW-1:0] acc,
  output logic          done
);
  logic [CW-1:0] last_q;
  logic [AW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      acc    <= '0;
      done   <= 1'b0;
      last_q <= '0;
      step_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        idx    <= '0;
        acc    <= '0;
        step_q <= step;
        last_q <= count - 1'b1;
        if (count == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (busy && ready) begin
        if (idx == last_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          acc <= acc + step_q;
        end
      end
    end
  end

  // R9: ascending element order on each accepted request
  a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ready) |=> (!busy || idx == $past(idx) + 1'b1));
  // R10: completion only reported when idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
  parameter int AW = 32,
  parameter int RW = 7,
  parameter int CW = 7
) (
  input  logic          gather,
  input  logic          dst_adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] gofs,
  input  logic [RW-1:0] rt,
  input  logic [RW-1:0] ra_first,
  input  logic [CW-1:0] idx,
  input  logic [AW-1:0] rf_rdata,
  output logic [RW-1:0] rf_raddr,
  output logic [AW-1:0] addr,
  output logic [RW-1:0] dst
);
  logic [RW-1:0] idx_r;
  assign idx_r    = RW'(idx);
  assign rf_raddr = ra_first + idx_r;
  assign addr     = gather ? (rf_rdata + gofs) : (base + acc);
  assign dst      = dst_adv ? (rt + idx_r) : rt;
endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq
  import vld_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RW  = 7,
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dst_vec,
  input  logic           ra_vec,
  input  logic           rb_vec,
  input  logic           idx_mode,
  input  logic           elem_stride,
  input  logic [1:0]     elem_size,
  input  logic [VLW-1:0] vl,
  input  logic [AW-1:0]  imm,
  input  logic [AW-1:0]  ra_val,
  input  logic [AW-1:0]  rb_val,
  input  logic [RW-1:0]  rt_num,
  input  logic [RW-1:0]  ra_num,
  output logic [RW-1:0]  rf_raddr,
  input  logic [AW-1:0]  rf_rdata,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [AW-1:0]  req_addr,
  output logic [RW-1:0]  req_dst,
  output logic           req_wen,
  output logic           busy,
  output logic           done,
  output logic           err
);
  amode_e        dec_mode;
  logic          dec_adv;
  logic          accept;
  logic [AW-1:0] sum_ab, sum_ai, base_in, step_in, unit_step;
  logic [VLW-1:0] cnt_in;

  logic          gather_q, adv_q, err_q;
  logic [AW-1:0] base_q, gofs_q;
  logic [RW-1:0] rt_q, ra_q;
  logic [VLW-1:0] idx;
  logic [AW-1:0] acc;

  vld_mode_decode u_dec (
    .dst_vec(dst_vec), .ra_vec(ra_vec), .rb_vec(rb_vec),
    .idx_mode(idx_mode), .elem_stride(elem_stride),
    .mode(dec_mode), .dst_adv(dec_adv)
  );

  assign accept    = start && !busy;
  assign sum_ab    = ra_val + rb_val;
  assign sum_ai    = ra_val + imm;
  assign unit_step = AW'(1) << elem_size;

  always_comb begin
    base_in = idx_mode ? sum_ab : sum_ai;
    step_in = '0;
    unique case (dec_mode)
      M_UNIT:     step_in = unit_step;
      M_ELSTRIDE: begin
        step_in = imm;
        base_in = ra_val;
      end
      default:    step_in = '0;
    endcase
    cnt_in = (dec_mode == M_SCALAR) ? VLW'(1) : vl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gather_q <= 1'b0;
      adv_q    <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
      gofs_q   <= '0;
      rt_q     <= '0;
      ra_q     <= '0;
    end else begin
      err_q <= accept && (dec_mode == M_BAD);
      if (accept) begin
        gather_q <= (dec_mode == M_GATHER);
        adv_q    <= dec_adv;
        base_q   <= base_in;
        gofs_q   <= idx_mode ? rb_val : imm;
        rt_q     <= rt_num;
        ra_q     <= ra_num;
      end
    end
  end

  vld_elem_ctr #(.CW(VLW), .AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .load(accept && (dec_mode != M_BAD)),
    .count(cnt_in), .step(step_in), .ready(req_ready),
    .busy(busy), .idx(idx), .acc(acc), .done(done)
  );

  vld_addr_gen #(.AW(AW), .RW(RW), .CW(VLW)) u_agen (
    .gather(gather_q), .dst_adv(adv_q), .base(base_q), .acc(acc),
    .gofs(gofs_q), .rt(rt_q), .ra_first(ra_q), .idx(idx),
    .rf_rdata(rf_rdata), .rf_raddr(rf_raddr),
    .addr(req_addr), .dst(req_dst)
  );

  assign req_valid = busy;
  assign req_wen   = busy;
  assign err       = err_q;

  // R9: a stalled request keeps its payload
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_dst)
                                   && (gather_q || $stable(req_addr))));
  // R11: a rejected operation issues nothing and completes nothing
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!req_valid && !done));
  // R4: fixed destination while streaming in select mode
  a_r4_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !adv_q && $past(req_valid)) |-> $stable(req_dst));
  // R12: start while busy changes no latched operand
  a_r12_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(rt_q) && $stable(base_q) && $stable(gofs_q)));
endmodule

// File: tb/sim_vld_addr_seq.sv
module sim_vld_addr_seq;
  typedef struct packed {
    logic        ix, dv, rav, rbv, es;
    logic [1:0]  sz;
    logic [6:0]  vl;
    logic [31:0] imm, ra, rb;
    logic [6:0]  rt, rai;
    logic        bp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd2,7'd4,32'h10,32'h1000,32'h0,7'd8,7'd3,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,7'd5,32'h3,32'h1100,32'h0,7'd2,7'd0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd0,7'd4,32'h20,32'h2000,32'h0,7'd10,7'd0,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,7'd4,32'h8,32'h0,32'h0,7'd20,7'd126,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,7'd3,32'h4,32'h0,32'h0,7'd5,7'd60,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,7'd9,32'h30,32'h3000,32'h0,7'd7,7'd0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,2'd3,7'd4,32'h0,32'h4000,32'h100,7'd12,7'd0,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'd1,7'd3,32'h0,32'h4800,32'h10,7'd40,7'd0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,2'd0,7'd3,32'h0,32'h0,32'h50,7'd30,7'd100,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,7'd4,32'h0,32'h5000,32'h8,7'd126,7'd0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,7'd3,32'h0,32'h6000,32'h4,7'd9,7'd0,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,7'd3,32'h0,32'h7000,32'h4,7'd9,7'd0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,7'd0,32'h0,32'h8000,32'h0,7'd1,7'd0,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic dst_vec = 0, ra_vec = 0, rb_vec = 0, idx_mode = 0, elem_stride = 0;
  logic [1:0] elem_size = '0;
  logic [6:0] vl = '0, rt_num = '0, ra_num = '0, rf_raddr, req_dst;
  logic [31:0] imm = '0, ra_val = '0, rb_val = '0, rf_rdata, req_addr;
  logic req_valid, req_ready = 1'b0, req_wen, busy, done, err;
  int total = 0, bad = 0, ticks = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] rfm(input logic [6:0] r);
    return 32'h8000_0000 + (32'(r) << 6);
  endfunction
  assign rf_rdata = rfm(rf_raddr);

  vld_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_vec(dst_vec), .ra_vec(ra_vec),
    .rb_vec(rb_vec), .idx_mode(idx_mode), .elem_stride(elem_stride),
    .elem_size(elem_size), .vl(vl), .imm(imm), .ra_val(ra_val), .rb_val(rb_val),
    .rt_num(rt_num), .ra_num(ra_num), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_dst(req_dst), .req_wen(req_wen), .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: R10 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_err(input vec_t v);
    return v.ix && !v.dv && (v.rav || v.rbv);
  endfunction
  function automatic int exp_n(input vec_t v);
    if (exp_err(v)) return 0;
    if (!v.dv && (v.ix || !v.rav)) return 1;
    return int'(v.vl);
  endfunction
  function automatic logic [31:0] exp_addr(input vec_t v, input int i);
    if (!v.ix) begin
      if (v.rav) return v.imm + rfm(7'(v.rai + i));
      if (v.es)  return v.ra + v.imm * 32'(i);
      if (v.dv)  return v.ra + v.imm + (32'(i) << v.sz);
      return v.ra + v.imm;
    end
    if (!v.dv) return v.ra + v.rb;
    if (v.rbv) return v.ra + v.rb + (32'(i) << v.sz);
    if (v.rav) return rfm(7'(v.rai + i)) + v.rb;
    return v.ra + v.rb;
  endfunction
  function automatic string tag_of(input vec_t v);
    if (exp_err(v)) return "R11";
    if (exp_n(v) == 1 && !v.dv) return "R5";
    if (v.vl == 0) return "R10";
    if (!v.ix) begin
      if (v.rav) return v.dv ? "R3" : "R4";
      return v.es ? "R2" : "R1";
    end
    if (v.rbv) return "R6";
    return v.rav ? "R7" : "R8";
  endfunction

  task automatic run_vec(input vec_t v, input bit restart);
    int n = 0, cyc = 0, last = -1, en;
    bit held = 0, fin = 0;
    logic [31:0] ha;
    logic [6:0] hd;
    string t;
    t = tag_of(v);
    en = exp_n(v);
    @(negedge clk);
    idx_mode = v.ix; dst_vec = v.dv; ra_vec = v.rav; rb_vec = v.rbv;
    elem_stride = v.es; elem_size = v.sz; vl = v.vl; imm = v.imm;
    ra_val = v.ra; rb_val = v.rb; rt_num = v.rt; ra_num = v.rai;
    start = 1'b1;
    @(negedge clk);
    start = restart;
    if (restart) begin vl = 7'd20; ra_val = 32'hDEAD_0000; rt_num = 7'd77; end
    while (!fin && cyc < 400) begin
      if (restart && cyc == 2) start = 1'b0;
      req_ready = v.bp ? ((cyc % 3) != 1) : 1'b1;
      if (restart && cyc < 2) req_ready = 1'b0;
      #1;
      if (held) check(req_valid && req_addr == ha && req_dst == {25'd0, hd} [6:0],
                      "R9", "stalled payload", req_addr, ha);
      held = req_valid && !req_ready;
      ha = req_addr; hd = req_dst;
      if (req_valid && req_ready) begin
        check(n < en, restart ? "R12" : t, "extra request", 32'(n), 32'(en));
        check(req_addr == exp_addr(v, n), t, "address", req_addr, exp_addr(v, n));
        check(req_dst == (v.dv ? 7'(v.rt + n) : v.rt), t, "destination",
              32'(req_dst), 32'(v.dv ? 7'(v.rt + n) : v.rt));
        check(req_wen, "R9", "write enable", 32'(req_wen), 32'd1);
        n++; last = cyc;
      end
      if (done) begin
        check(n == en, restart ? "R12" : t, "element count", 32'(n), 32'(en));
        check(cyc == last + 1, "R10", "done timing", 32'(cyc), 32'(last + 1));
        fin = 1;
      end
      if (err) begin
        check(exp_err(v) && cyc == 0, "R11", "err timing", 32'(cyc), 32'd0);
        fin = 1;
      end
      cyc++;
      if (!fin) @(negedge clk);
    end
    check(fin, t, "operation ended", 32'(fin), 32'd1);
    if (exp_err(v)) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        check(!req_valid && !done, "R11", "quiet after err",
              {30'd0, req_valid, done}, 32'd0);
      end
    end
    start = 1'b0;
    req_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!req_valid && !done && !err && !busy, "R13", "reset outputs",
          {28'd0, req_valid, done, err, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!req_valid && !done && !err && !busy, "R13", "idle after reset",
          {28'd0, req_valid, done, err, busy}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], 1'b0);

    // R12: start pulses during a running operation are ignored
    run_vec(TBL[0], 1'b1);

    // R13: reset during an operation clears the stream
    @(negedge clk);
    idx_mode = 0; dst_vec = 1; ra_vec = 0; rb_vec = 0; elem_stride = 0;
    vl = 7'd8; start = 1'b1; req_ready = 1'b0;
    @(negedge clk); start = 1'b0; #1;
    check(req_valid && busy, "R13", "running before reset", 32'(req_valid), 32'd1);
    rst_n = 1'b0;
    @(negedge clk); #1;
    check(!req_valid && !busy && !done, "R13", "reset mid-op",
          {29'd0, req_valid, busy, done}, 32'd0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule